// File: doc/BRIEF.md
# Banked CPU Register File

This block is the architectural register storage for an 8-bit processor core. It holds eight byte registers that the datapath also sees as four 16-bit pairs, a second hidden copy of those four pairs, two 16-bit index registers, the stack pointer and the program counter. The decoder reads through one byte port and one pair port, both combinational. It writes through one byte port and one pair port, which take effect at the clock edge.

The hidden copies cannot be addressed. They are reached only by exchange strobes. One strobe swaps the accumulator/flags pair with its copy. A second strobe swaps the other three pairs with theirs. A third strobe trades the DE and HL contents with each other. An index-select input lets an instruction prefix retarget every HL, H or L access to one of the two index registers. The DE/HL trade is the one operation that ignores this input.

Top module: `cpu_regbank`

## Requirements
- R1: Byte codes are A=0, F=1, B=2, C=3, D=4, E=5, H=6, L=7. Pair codes are AF=0, BC=1, DE=2, HL=3, SP=4, PC=5, IX=6, IY=7. In each pair the first-named byte is bits 15:8.
- R2: Reads are combinational from current contents. A write becomes visible after the next rising clock edge, and a register with no write or exchange keeps its value.
- R3: No read or write code reaches a hidden copy. A write never changes a hidden copy.
- R4: `swap_af` exchanges all 16 bits of AF with its hidden copy in one clock. A second exchange restores both values.
- R5: `swap_main` exchanges BC, DE and HL with their hidden copies in one clock. It leaves AF alone, and `swap_af` leaves BC, DE and HL alone.
- R6: `idx_sel` selects the HL target: 0 or 3 selects HL, 1 selects IX and 2 selects IY. The redirect applies to byte codes H and L (H maps to the high byte) and to pair code HL, on reads and on writes.
- R7: `swap_de_hl` exchanges DE with the real HL whatever `idx_sel` holds. IX and IY do not change.
- R8: In one cycle the order is `swap_af`, then `swap_main`, then `swap_de_hl`, then the pair write, then the byte write. A write therefore lands in the register that has just become active.
- R9: When the byte write and the pair write hit the same pair, the byte write sets its byte and the pair write supplies the other byte.
- R10: Pair codes 4 to 7 (SP, PC, IX, IY) address their registers directly, whatever `idx_sel` holds.
- R11: Reset is asynchronous and active low. It sets PC to 0x0000, SP to 0xDFF0 and IX and IY to 0xFFFF. Every other main register and every hidden copy is set to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_sel | input | 2 | HL retarget: 1 selects IX, 2 selects IY, otherwise HL |
| byte_rd_sel | input | 3 | Byte read code |
| byte_rd_data | output | 8 | Byte read value |
| pair_rd_sel | input | 3 | Pair read code |
| pair_rd_data | output | 16 | Pair read value |
| byte_wr_en | input | 1 | Byte write enable |
| byte_wr_sel | input | 3 | Byte write code |
| byte_wr_data | input | 8 | Byte write value |
| pair_wr_en | input | 1 | Pair write enable |
| pair_wr_sel | input | 3 | Pair write code |
| pair_wr_data | input | 16 | Pair write value |
| swap_af | input | 1 | Exchange AF with its hidden copy |
| swap_main | input | 1 | Exchange BC, DE and HL with their hidden copies |
| swap_de_hl | input | 1 | Exchange DE with the real HL |

## Verification
The risky overlap is an exchange and a write that hit the same pair in the same clock. Without a defined order, the write could land in the copy that is about to be hidden. The bench drives `swap_main` together with a pair write to BC, and `swap_af` together with byte and pair writes to AF. It also drives `swap_main` together with `swap_de_hl`. Each result is judged by reading the active pair straight away and the hidden pair after swapping it back out. The reference model applies the ordering from R8 step by step.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int BYTE_W    = 8;
  localparam int PAIR_W    = 2 * BYTE_W;
  localparam int NUM_WORDS = 8;
  localparam int NUM_BANK  = 4;
  localparam int SEL_W     = $clog2(NUM_WORDS);

  localparam logic [SEL_W-1:0] PS_AF = 3'd0;
  localparam logic [SEL_W-1:0] PS_BC = 3'd1;
  localparam logic [SEL_W-1:0] PS_DE = 3'd2;
  localparam logic [SEL_W-1:0] PS_HL = 3'd3;
  localparam logic [SEL_W-1:0] PS_SP = 3'd4;
  localparam logic [SEL_W-1:0] PS_PC = 3'd5;
  localparam logic [SEL_W-1:0] PS_IX = 3'd6;
  localparam logic [SEL_W-1:0] PS_IY = 3'd7;

  localparam logic [SEL_W-1:0] BS_A = 3'd0;
  localparam logic [SEL_W-1:0] BS_H = 3'd6;

  localparam logic [1:0] IX_MODE = 2'd1;
  localparam logic [1:0] IY_MODE = 2'd2;

  typedef logic [PAIR_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Apply the prefix retarget to a pair code.
  function automatic logic [SEL_W-1:0] retarget(input logic [SEL_W-1:0] code,
                                               input logic [1:0] mode);
    if (code != PS_HL)        return code;
    else if (mode == IX_MODE) return PS_IX;
    else if (mode == IY_MODE) return PS_IY;
    else                      return PS_HL;
  endfunction

  // Pair that holds a byte code (two bytes per pair).
  function automatic logic [SEL_W-1:0] byte_home(input logic [SEL_W-1:0] bcode);
    return {1'b0, bcode[SEL_W-1:1]};
  endfunction

  // Even byte codes name the high byte.
  function automatic logic byte_is_high(input logic [SEL_W-1:0] bcode);
    return ~bcode[0];
  endfunction

  // Overlay optional byte writes on a word.
  function automatic word_t overlay(input word_t base,
                                    input logic hi_en, input byte_t hi_d,
                                    input logic lo_en, input byte_t lo_d);
    word_t r;
    r = base;
    if (hi_en) r[PAIR_W-1:BYTE_W] = hi_d;
    if (lo_en) r[BYTE_W-1:0]      = lo_d;
    return r;
  endfunction
endpackage

// File: rtl/rb_word_reg.sv
module rb_word_reg
  import regbank_pkg::*;
#(
  parameter word_t RESET_VAL = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hi_en,
  input  byte_t hi_d,
  input  logic  lo_en,
  input  byte_t lo_d,
  output word_t q
);
  word_t q_r;
  word_t q_next;

  always_comb q_next = overlay(q_r, hi_en, hi_d, lo_en, lo_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RESET_VAL;
    else        q_r <= q_next;
  end

  assign q = q_r;

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_en && !lo_en) |=> q_r == $past(q_r)); // R2
  AST_WORD_HIGH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    hi_en |=> q_r[PAIR_W-1:BYTE_W] == $past(hi_d)); // R2
endmodule

// File: rtl/rb_banked_pair.sv
module rb_banked_pair
  import regbank_pkg::*;
#(
  parameter word_t MAIN_RESET   = '0,
  parameter word_t SHADOW_RESET = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  swap_i,
  input  logic  load_en_i,
  input  word_t peer_i,
  input  logic  hi_en,
  input  byte_t hi_d,
  input  logic  lo_en,
  input  byte_t lo_d,
  output word_t main_o,
  output word_t staged_o
);
  word_t main_r, shadow_r;
  word_t staged, loaded, main_next, shadow_next;

  always_comb begin
    staged      = swap_i ? shadow_r : main_r;
    shadow_next = swap_i ? main_r   : shadow_r;
    loaded      = load_en_i ? peer_i : staged;
    main_next   = overlay(loaded, hi_en, hi_d, lo_en, lo_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_r   <= MAIN_RESET;
      shadow_r <= SHADOW_RESET;
    end else begin
      main_r   <= main_next;
      shadow_r <= shadow_next;
    end
  end

  assign main_o   = main_r;
  assign staged_o = staged;

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_i |=> shadow_r == $past(shadow_r)); // R3
  AST_SWAP_TO_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    swap_i |=> shadow_r == $past(main_r)); // R4
  AST_SWAP_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_i && hi_en && lo_en) |=> main_r == $past({hi_d, lo_d})); // R8
endmodule

// File: rtl/rb_write_route.sv
module rb_write_route
  import regbank_pkg::*;
(
  input  logic [1:0]                     idx_sel,
  input  logic                           byte_wr_en,
  input  logic [SEL_W-1:0]               byte_wr_sel,
  input  byte_t                          byte_wr_data,
  input  logic                           pair_wr_en,
  input  logic [SEL_W-1:0]               pair_wr_sel,
  input  word_t                          pair_wr_data,
  output logic [NUM_WORDS-1:0]           hi_en,
  output logic [NUM_WORDS-1:0]           lo_en,
  output logic [NUM_WORDS-1:0][BYTE_W-1:0] hi_d,
  output logic [NUM_WORDS-1:0][BYTE_W-1:0] lo_d
);
  logic [SEL_W-1:0] pair_tgt, byte_tgt;
  logic             byte_hi;

  always_comb begin
    pair_tgt = retarget(pair_wr_sel, idx_sel);
    byte_tgt = retarget(byte_home(byte_wr_sel), idx_sel);
    byte_hi  = byte_is_high(byte_wr_sel);
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_lane
    logic pair_hit, bhit_hi, bhit_lo;
    always_comb begin
      pair_hit = pair_wr_en && (pair_tgt == SEL_W'(w));
      bhit_hi  = byte_wr_en && byte_hi  && (byte_tgt == SEL_W'(w));
      bhit_lo  = byte_wr_en && !byte_hi && (byte_tgt == SEL_W'(w));
      hi_en[w] = pair_hit || bhit_hi;
      lo_en[w] = pair_hit || bhit_lo;
      hi_d[w]  = bhit_hi ? byte_wr_data : pair_wr_data[PAIR_W-1:BYTE_W];
      lo_d[w]  = bhit_lo ? byte_wr_data : pair_wr_data[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/rb_read_mux.sv
module rb_read_mux
  import regbank_pkg::*;
(
  input  logic [NUM_WORDS-1:0][PAIR_W-1:0] words,
  input  logic [1:0]                       idx_sel,
  input  logic [SEL_W-1:0]                 byte_rd_sel,
  input  logic [SEL_W-1:0]                 pair_rd_sel,
  output byte_t                            byte_rd_data,
  output word_t                            pair_rd_data
);
  logic [SEL_W-1:0] bsrc, psrc;
  word_t            bword;

  always_comb begin
    bsrc         = retarget(byte_home(byte_rd_sel), idx_sel);
    psrc         = retarget(pair_rd_sel, idx_sel);
    bword        = words[bsrc];
    byte_rd_data = byte_is_high(byte_rd_sel) ? bword[PAIR_W-1:BYTE_W] : bword[BYTE_W-1:0];
    pair_rd_data = words[psrc];
  end
endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
  import regbank_pkg::*;
#(
  parameter logic [15:0] SP_RESET  = 16'hDFF0,
  parameter logic [15:0] PC_RESET  = 16'h0000,
  parameter logic [15:0] IDX_RESET = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  idx_sel,
  input  logic [2:0]  byte_rd_sel,
  output logic [7:0]  byte_rd_data,
  input  logic [2:0]  pair_rd_sel,
  output logic [15:0] pair_rd_data,
  input  logic        byte_wr_en,
  input  logic [2:0]  byte_wr_sel,
  input  logic [7:0]  byte_wr_data,
  input  logic        pair_wr_en,
  input  logic [2:0]  pair_wr_sel,
  input  logic [15:0] pair_wr_data,
  input  logic        swap_af,
  input  logic        swap_main,
  input  logic        swap_de_hl
);
  logic [NUM_WORDS-1:0][PAIR_W-1:0] words;
  logic [NUM_BANK-1:0][PAIR_W-1:0]  staged;
  logic [NUM_WORDS-1:0]             hi_en, lo_en;
  logic [NUM_WORDS-1:0][BYTE_W-1:0] hi_d, lo_d;

  // Bank-level exchange events brought out for checking.
  logic ev_dehl_swap;
  logic ev_any_write;
  assign ev_dehl_swap = swap_de_hl;
  assign ev_any_write = byte_wr_en || pair_wr_en;

  rb_write_route u_route (
    .idx_sel      (idx_sel),
    .byte_wr_en   (byte_wr_en),
    .byte_wr_sel  (byte_wr_sel),
    .byte_wr_data (byte_wr_data),
    .pair_wr_en   (pair_wr_en),
    .pair_wr_sel  (pair_wr_sel),
    .pair_wr_data (pair_wr_data),
    .hi_en        (hi_en),
    .lo_en        (lo_en),
    .hi_d         (hi_d),
    .lo_d         (lo_d)
  );

  // Banked pairs: AF swaps alone, BC/DE/HL swap together; DE and HL trade as peers.
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    localparam int PEER = b ^ 1;
    logic swap_b, load_b;
    assign swap_b = (b == 0) ? swap_af : swap_main;
    assign load_b = (b >= 2) ? swap_de_hl : 1'b0;
    rb_banked_pair #(.MAIN_RESET('0), .SHADOW_RESET('0)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .swap_i    (swap_b),
      .load_en_i (load_b),
      .peer_i    (staged[PEER]),
      .hi_en     (hi_en[b]),
      .hi_d      (hi_d[b]),
      .lo_en     (lo_en[b]),
      .lo_d      (lo_d[b]),
      .main_o    (words[b]),
      .staged_o  (staged[b])
    );
  end

  // Unbanked words: SP, PC, IX, IY.
  for (genvar w = NUM_BANK; w < NUM_WORDS; w++) begin : g_word
    localparam word_t RV = (w == int'(PS_SP)) ? SP_RESET :
                           (w == int'(PS_PC)) ? PC_RESET : IDX_RESET;
    rb_word_reg #(.RESET_VAL(RV)) u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .hi_en (hi_en[w]),
      .hi_d  (hi_d[w]),
      .lo_en (lo_en[w]),
      .lo_d  (lo_d[w]),
      .q     (words[w])
    );
  end

  rb_read_mux u_read (
    .words        (words),
    .idx_sel      (idx_sel),
    .byte_rd_sel  (byte_rd_sel),
    .pair_rd_sel  (pair_rd_sel),
    .byte_rd_data (byte_rd_data),
    .pair_rd_data (pair_rd_data)
  );

  AST_DEHL_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dehl_swap && !ev_any_write) |=>
      (words[PS_IX] == $past(words[PS_IX])) && (words[PS_IY] == $past(words[PS_IY]))); // R7
  AST_IDX_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr_en && byte_wr_sel == BS_H && idx_sel == IX_MODE) |=>
      words[PS_IX][PAIR_W-1:BYTE_W] == $past(byte_wr_data)); // R6
  AST_PAIR_BYTE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rd_sel == BS_A && pair_rd_sel == PS_AF) |->
      byte_rd_data == pair_rd_data[PAIR_W-1:BYTE_W]); // R1
  AST_AF_SWAP_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_af && !swap_main && !swap_de_hl && !ev_any_write) |=>
      words[PS_BC] == $past(words[PS_BC])); // R5
endmodule

// File: tb/cpu_regbank_bench.sv
module cpu_regbank_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  idx_sel = '0;
  logic [2:0]  byte_rd_sel = '0;
  logic [7:0]  byte_rd_data;
  logic [2:0]  pair_rd_sel = '0;
  logic [15:0] pair_rd_data;
  logic        byte_wr_en = 1'b0;
  logic [2:0]  byte_wr_sel = '0;
  logic [7:0]  byte_wr_data = '0;
  logic        pair_wr_en = 1'b0;
  logic [2:0]  pair_wr_sel = '0;
  logic [15:0] pair_wr_data = '0;
  logic        swap_af = 1'b0;
  logic        swap_main = 1'b0;
  logic        swap_de_hl = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cpu_regbank u_cpu_regbank (
    .clk(clk), .rst_n(rst_n), .idx_sel(idx_sel),
    .byte_rd_sel(byte_rd_sel), .byte_rd_data(byte_rd_data),
    .pair_rd_sel(pair_rd_sel), .pair_rd_data(pair_rd_data),
    .byte_wr_en(byte_wr_en), .byte_wr_sel(byte_wr_sel), .byte_wr_data(byte_wr_data),
    .pair_wr_en(pair_wr_en), .pair_wr_sel(pair_wr_sel), .pair_wr_data(pair_wr_data),
    .swap_af(swap_af), .swap_main(swap_main), .swap_de_hl(swap_de_hl)
  );

  // Reference state: index 0..7 follows the pair codes; hid holds the four hidden copies.
  logic [15:0] ref_w [8];
  logic [15:0] hid   [4];

  // Scoreboard: bit 16 says pair port, low 16 bits the expected value.
  logic [16:0] expq [$];
  string       tagq [$];

  function automatic int where(input int code, input logic [1:0] mode);
    if (code == 3 && mode == 2'd1) return 6;
    if (code == 3 && mode == 2'd2) return 7;
    return code;
  endfunction

  task automatic op(input bit bwe, input logic [2:0] bs, input logic [7:0] bd,
                    input bit pwe, input logic [2:0] ps, input logic [15:0] pd,
                    input bit xa, input bit xm, input bit xd, input logic [1:0] mode);
    logic [15:0] t;
    int k;
    @(negedge clk);
    byte_wr_en = bwe; byte_wr_sel = bs; byte_wr_data = bd;
    pair_wr_en = pwe; pair_wr_sel = ps; pair_wr_data = pd;
    swap_af = xa; swap_main = xm; swap_de_hl = xd; idx_sel = mode;
    if (xa) begin t = ref_w[0]; ref_w[0] = hid[0]; hid[0] = t; end
    if (xm) for (int j = 1; j < 4; j++) begin t = ref_w[j]; ref_w[j] = hid[j]; hid[j] = t; end
    if (xd) begin t = ref_w[2]; ref_w[2] = ref_w[3]; ref_w[3] = t; end
    if (pwe) ref_w[where(int'(ps), mode)] = pd;
    if (bwe) begin
      k = where(int'(bs) / 2, mode);
      if (bs[0] == 1'b0) ref_w[k][15:8] = bd; else ref_w[k][7:0] = bd;
    end
    @(negedge clk);
    byte_wr_en = 1'b0; pair_wr_en = 1'b0;
    swap_af = 1'b0; swap_main = 1'b0; swap_de_hl = 1'b0;
  endtask

  task automatic put_pair(input logic [2:0] ps, input logic [15:0] pd, input logic [1:0] mode);
    op(0, 0, 0, 1, ps, pd, 0, 0, 0, mode);
  endtask

  task automatic chk_pair(input logic [2:0] ps, input logic [1:0] mode, input string tag);
    @(negedge clk);
    pair_rd_sel = ps; idx_sel = mode;
    expq.push_back({1'b1, ref_w[where(int'(ps), mode)]});
    tagq.push_back(tag);
  endtask

  task automatic chk_byte(input logic [2:0] bs, input logic [1:0] mode, input string tag);
    logic [15:0] w;
    @(negedge clk);
    byte_rd_sel = bs; idx_sel = mode;
    w = ref_w[where(int'(bs) / 2, mode)];
    expq.push_back({1'b0, 8'h00, (bs[0] ? w[7:0] : w[15:8])});
    tagq.push_back(tag);
  endtask

  // Bring the hidden copies into view, read them, then put them back.
  task automatic chk_hidden(input string tag);
    op(0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    for (int p = 0; p < 4; p++) chk_pair(3'(p), 0, tag);
    op(0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
  endtask

  // Monitor: compare a quarter period after each falling edge.
  always @(negedge clk) begin
    logic [16:0] item;
    logic [15:0] got;
    string tg;
    #(CLK_P/4);
    if (expq.size() > 0) begin
      item = expq.pop_front();
      tg = tagq.pop_front();
      got = item[16] ? pair_rd_data : {8'h00, byte_rd_data};
      n_cmp++;
      if (got !== item[15:0]) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", tg, got, item[15:0]);
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) ref_w[i] = 16'h0000;
    for (int i = 0; i < 4; i++) hid[i] = 16'h0000;
    ref_w[4] = 16'hDFF0; ref_w[6] = 16'hFFFF; ref_w[7] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset values, main and hidden
    for (int p = 0; p < 8; p++) chk_pair(3'(p), 0, "R11 reset main");
    chk_hidden("R11 reset hidden");

    // R1 / R2: pair writes, byte view, high byte first
    put_pair(3'd0, 16'hABCD, 0);
    put_pair(3'd1, 16'h1122, 0);
    put_pair(3'd2, 16'h3344, 0);
    put_pair(3'd3, 16'h5566, 0);
    for (int b = 0; b < 8; b++) chk_byte(3'(b), 0, "R1 byte view");
    chk_pair(3'd0, 0, "R1 AF pair");
    op(1, 3'd3, 8'h9C, 0, 0, 0, 0, 0, 0, 0);
    chk_pair(3'd1, 0, "R2 byte write C");

    // R4: AF exchange, twice restores
    op(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk_pair(3'd0, 0, "R4 AF after swap");
    put_pair(3'd0, 16'h1234, 0);
    op(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk_pair(3'd0, 0, "R4 AF restored");
    op(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk_pair(3'd0, 0, "R4 AF second swap");
    op(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);

    // R3: writes never reach hidden copies
    put_pair(3'd2, 16'h7777, 0);
    op(1, 3'd7, 8'h42, 0, 0, 0, 0, 0, 0, 0);
    chk_hidden("R3 hidden untouched");

    // R5: main swap leaves AF; AF swap leaves BC
    op(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk_pair(3'd0, 0, "R5 AF kept");
    chk_pair(3'd1, 0, "R5 BC swapped");
    chk_pair(3'd3, 0, "R5 HL swapped");
    op(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk_pair(3'd1, 0, "R5 BC kept on AF swap");
    op(0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    chk_pair(3'd0, 0, "R5 both strobes AF");
    chk_pair(3'd2, 0, "R5 both strobes DE");

    // R6: index redirect on writes and reads
    put_pair(3'd3, 16'hA0A1, 2'd1);
    op(1, 3'd6, 8'h5E, 0, 0, 0, 0, 0, 0, 2'd2);
    op(1, 3'd7, 8'h3C, 0, 0, 0, 0, 0, 0, 2'd1);
    chk_pair(3'd3, 2'd1, "R6 HL as IX");
    chk_pair(3'd3, 2'd2, "R6 HL as IY");
    chk_pair(3'd3, 2'd0, "R6 real HL");
    chk_pair(3'd3, 2'd3, "R6 mode 3 is HL");
    chk_byte(3'd6, 2'd2, "R6 H as IY high");
    chk_byte(3'd7, 2'd1, "R6 L as IX low");

    // R7: DE/HL trade ignores index select
    op(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd1);
    chk_pair(3'd2, 0, "R7 DE gets HL");
    chk_pair(3'd3, 0, "R7 HL gets DE");
    chk_pair(3'd6, 0, "R7 IX unchanged");
    chk_pair(3'd7, 0, "R7 IY unchanged");

    // R8: exchange and write in one cycle
    op(0, 0, 0, 1, 3'd1, 16'hBEEF, 0, 1, 0, 0);
    chk_pair(3'd1, 0, "R8 write to new BC");
    chk_hidden("R8 hidden BC keeps old");
    op(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    chk_pair(3'd2, 0, "R8 exx then DE/HL DE");
    chk_pair(3'd3, 0, "R8 exx then DE/HL HL");
    chk_hidden("R8 exx then DE/HL hidden");
    op(1, 3'd1, 8'h5A, 1, 3'd0, 16'hC3D4, 1, 0, 0, 0);
    chk_pair(3'd0, 0, "R8 AF swap with writes");

    // R9: byte write wins over pair write on its byte
    op(1, 3'd4, 8'hEE, 1, 3'd2, 16'h1357, 0, 0, 0, 0);
    chk_pair(3'd2, 0, "R9 DE merge high");
    op(1, 3'd7, 8'h01, 1, 3'd3, 16'h2468, 0, 0, 0, 2'd2);
    chk_pair(3'd7, 0, "R9 IY merge low");

    // R10: direct codes ignore index select
    put_pair(3'd4, 16'hC000, 2'd1);
    put_pair(3'd5, 16'h0100, 2'd2);
    put_pair(3'd6, 16'h4321, 2'd2);
    chk_pair(3'd4, 2'd2, "R10 SP");
    chk_pair(3'd5, 2'd1, "R10 PC");
    chk_pair(3'd6, 2'd2, "R10 IX direct");
    chk_pair(3'd7, 2'd1, "R10 IY direct");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule